// File: doc/BRIEF.md
# Flat and Global Memory Address Router

This unit sits between the vector issue stage and the memory pipelines of a shader core. For each flat or global vector memory instruction it works out one byte address per lane. It also decides whether that lane's request goes to the global memory pipeline or to the workgroup-local memory pipeline. A start pulse captures the instruction-level context: the mode, a 7-bit scalar-address selector, a 32-bit scalar base, a 32-bit immediate offset and the execution mask. After that, lanes arrive one per cycle in ascending order. Each lane carries a 64-bit per-lane address and a 2-bit segment code that an aperture check upstream has already resolved.

Addressing depends on the mode. Flat instructions always add the offset to the full 64-bit lane address. Global instructions do the same only when the selector holds the reserved "no scalar base" value 0x7F. Any other selector means the scalar base is added as well, and the sum is truncated to 32 bits. Every global instruction goes to the global pipe. A flat lane is steered by its segment code. A segment code that is neither global nor group raises an error flag, which stays set until the next start pulse.

Top module: `fga_unit`

## Requirements
- R1: After reset, `out_valid_o` and `err_o` are 0.
- R2: In global mode (`mode_flat_i`=0) with selector 0x7F, the lane address is `lane_addr_i + offset` over the full 64 bits, with carries out of bit 31 kept. The offset is zero-extended.
- R3: In flat mode (`mode_flat_i`=1), the lane address is the 64-bit `lane_addr_i + offset`, whatever the selector value.
- R4: In global mode with any selector other than 0x7F, the lane address is `(lane_addr_i[31:0] + scalar base + offset) mod 2^32`, and bits 63:32 of the output are zero.
- R5: Every global-mode lane is sent to the global pipe (`out_pipe_o`=0) whatever its segment code, and never raises the error.
- R6: In flat mode, segment code 0 (global) routes to `out_pipe_o`=0 and segment code 1 (group) routes to `out_pipe_o`=1.
- R7: In flat mode, segment codes 2 and 3 produce no output for that lane and set `err_o`.
- R8: `err_o` stays set until a start pulse, and reads 0 in the cycle after that pulse.
- R9: A lane whose execution-mask bit is 0 produces no output, but it still consumes its lane index.
- R10: Each accepted lane appears on the outputs exactly one cycle after it is presented. `out_lane_o` gives its index: 0 for the first lane presented after start, counting up by one for each lane presented.
- R11: A lane presented in the same cycle as a start pulse is ignored. Lanes presented after all lanes of the instruction have been consumed are ignored until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins an instruction; captures context and clears the error |
| mode_flat_i | input | 1 | 1 = flat instruction, 0 = global instruction |
| sel_i | input | 7 | Scalar-address selector; 0x7F means no scalar base |
| sbase_i | input | 32 | Scalar base value |
| offset_i | input | 32 | Immediate offset, unsigned |
| exec_mask_i | input | NUM_LANES | Execution mask, bit n for lane n |
| lane_valid_i | input | 1 | A lane is presented this cycle |
| lane_addr_i | input | 64 | Per-lane address |
| lane_seg_i | input | 2 | Resolved segment: 0 global, 1 group, 2/3 unsupported |
| out_valid_o | output | 1 | A routed lane request is present |
| out_lane_o | output | $clog2(NUM_LANES) | Lane index of the request |
| out_addr_o | output | 64 | Computed lane address |
| out_pipe_o | output | 1 | 0 = global pipe, 1 = local pipe |
| err_o | output | 1 | Sticky unsupported-segment error |

## Verification
The error is the only output that outlives a lane. If the captured mode or the error register is corrupted, the fault shows up either as a flag that stays set after a start pulse or as a flag that never rises for an unsupported flat segment. Either is visible one cycle after the triggering input. A lane counter that goes wrong shows at once as a wrong `out_lane_o` on the next lane. It also shows as masked lanes producing output, or as overflow lanes getting through. A corrupted selector or base capture gives a wrong address on every lane of the instruction, starting with the first. Each scenario therefore samples the outputs one cycle after each presented lane and checks the error on the cycle after each start.

// File: rtl/fga_pkg.sv
// Shared constants and types of the flat/global address router.
// Assumes a 64-bit lane address space and 32-bit scalar operands.
package fga_pkg;
    localparam int ADDR_W   = 64;
    localparam int NARROW_W = 32;
    localparam int SEL_W    = 7;
    localparam int SEG_W    = 2;

    // Selector value that means "no scalar base, use full-width lane address".
    localparam logic [SEL_W-1:0] SEL_NO_BASE = 7'h7F;

    // Resolved segment codes; the two remaining codes are unsupported.
    localparam logic [SEG_W-1:0] SEG_GLOBAL = 2'd0;
    localparam logic [SEG_W-1:0] SEG_GROUP  = 2'd1;

    typedef enum logic {
        PIPE_GLOBAL = 1'b0,
        PIPE_LOCAL  = 1'b1
    } pipe_e;

    // Per-instruction context captured on the start pulse.
    typedef struct packed {
        logic                flat;
        logic [SEL_W-1:0]    sel;
        logic [NARROW_W-1:0] sbase;
        logic [NARROW_W-1:0] offset;
    } ctx_t;
endpackage

// File: rtl/fga_addr_calc.sv
// Combinational address generator for one lane.
// Assumes the caller has already decided between full-width and narrow
// (base-plus-offset, truncated) addressing through wide_en_i.
module fga_addr_calc
    import fga_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NARROW_W
) (
    input  logic          wide_en_i,
    input  logic [AW-1:0] lane_addr_i,
    input  logic [NW-1:0] sbase_i,
    input  logic [NW-1:0] offset_i,
    output logic [AW-1:0] addr_o
);
    localparam int PAD_W = AW - NW;

    logic [AW-1:0] wide_sum;
    logic [NW-1:0] narrow_sum;
    logic [AW-1:0] narrow_ext;

    // Full-width form: lane address plus zero-extended offset.
    always_comb begin
        wide_sum = lane_addr_i + {{PAD_W{1'b0}}, offset_i};
    end

    // Narrow form: low lane bits plus base plus offset, wrapping at NW bits.
    always_comb begin
        narrow_sum = lane_addr_i[NW-1:0] + sbase_i + offset_i;
    end

    // Zero-extend the narrow form to the output width.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb narrow_ext = {{PAD_W{1'b0}}, narrow_sum};
        end else begin : g_nopad
            always_comb narrow_ext = narrow_sum[AW-1:0];
        end
    endgenerate

    // Select the addressing form.
    always_comb begin
        addr_o = wide_en_i ? wide_sum : narrow_ext;
    end
endmodule

// File: rtl/fga_route.sv
// Combinational pipe selection for one lane.
// Assumes the segment code has been resolved upstream; global
// instructions ignore it entirely.
module fga_route
    import fga_pkg::*;
(
    input  logic             flat_i,
    input  logic [SEG_W-1:0] seg_i,
    output pipe_e            pipe_o,
    output logic             bad_o
);
    // Decode the target pipe and flag unsupported flat segments.
    always_comb begin
        pipe_o = PIPE_GLOBAL;
        bad_o  = 1'b0;
        if (flat_i) begin
            unique case (seg_i)
                SEG_GLOBAL: pipe_o = PIPE_GLOBAL;
                SEG_GROUP:  pipe_o = PIPE_LOCAL;
                default:    bad_o  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/fga_lane_seq.sv
// Lane sequencer: captures the execution mask on start, numbers the
// lanes as they arrive and decides which of them are accepted and active.
// Assumes lanes arrive in ascending order, at most one per cycle.
module fga_lane_seq #(
    parameter int NUM_LANES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_LANES-1:0] mask_i,
    input  logic                 lane_valid_i,
    output logic                 active_o,
    output logic [$clog2(NUM_LANES)-1:0] idx_o
);
    localparam int LANE_W = $clog2(NUM_LANES);
    localparam int CNT_W  = LANE_W + 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(NUM_LANES);

    logic [CNT_W-1:0]     cnt_q;
    logic [NUM_LANES-1:0] mask_q;
    logic                 accept;

    // A lane is taken when not in a start cycle and lanes remain.
    always_comb begin
        accept   = lane_valid_i && !start_i && (cnt_q < CNT_END);
        idx_o    = cnt_q[LANE_W-1:0];
        active_o = accept && mask_q[idx_o];
    end

    // Lane counter: rewinds on start, advances on every accepted lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_END;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Execution-mask capture for the current instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (start_i) begin
            mask_q <= mask_i;
        end
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_END)
        else $error("lane counter beyond lane count");

    p_start_rewind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0))
        else $error("start did not rewind lane counter");
endmodule

// File: rtl/fga_unit.sv
// Flat/global address router top. Captures instruction context on start,
// then for each presented lane computes its address and target pipe and
// registers the result with one cycle of latency. Unsupported flat
// segments set a sticky error that only a start pulse clears.
// Assumes the segment decode upstream and the memory pipes downstream.
module fga_unit
    import fga_pkg::*;
#(
    parameter int NUM_LANES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         mode_flat_i,
    input  logic [SEL_W-1:0]             sel_i,
    input  logic [NARROW_W-1:0]          sbase_i,
    input  logic [NARROW_W-1:0]          offset_i,
    input  logic [NUM_LANES-1:0]         exec_mask_i,
    input  logic                         lane_valid_i,
    input  logic [ADDR_W-1:0]            lane_addr_i,
    input  logic [SEG_W-1:0]             lane_seg_i,
    output logic                         out_valid_o,
    output logic [$clog2(NUM_LANES)-1:0] out_lane_o,
    output logic [ADDR_W-1:0]            out_addr_o,
    output logic                         out_pipe_o,
    output logic                         err_o
);
    localparam int LANE_W = $clog2(NUM_LANES);

    ctx_t              ctx_q;
    logic              wide_en;
    logic              lane_active;
    logic [LANE_W-1:0] lane_idx;
    logic [ADDR_W-1:0] lane_addr_calc;
    pipe_e             lane_pipe;
    logic              lane_bad;

    // Instruction context capture on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (start_i) begin
            ctx_q.flat   <= mode_flat_i;
            ctx_q.sel    <= sel_i;
            ctx_q.sbase  <= sbase_i;
            ctx_q.offset <= offset_i;
        end
    end

    // Flat always uses full width; global only with the reserved selector.
    always_comb begin
        wide_en = ctx_q.flat || (ctx_q.sel == SEL_NO_BASE);
    end

    fga_lane_seq #(.NUM_LANES(NUM_LANES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mask_i       (exec_mask_i),
        .lane_valid_i (lane_valid_i),
        .active_o     (lane_active),
        .idx_o        (lane_idx)
    );

    fga_addr_calc #(.AW(ADDR_W), .NW(NARROW_W)) u_addr (
        .wide_en_i   (wide_en),
        .lane_addr_i (lane_addr_i),
        .sbase_i     (ctx_q.sbase),
        .offset_i    (ctx_q.offset),
        .addr_o      (lane_addr_calc)
    );

    fga_route u_route (
        .flat_i (ctx_q.flat),
        .seg_i  (lane_seg_i),
        .pipe_o (lane_pipe),
        .bad_o  (lane_bad)
    );

    // Output valid: an active lane with a supported route; start squashes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
        end else begin
            out_valid_o <= lane_active && !lane_bad && !start_i;
        end
    end

    // Output payload, loaded only for active lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lane_o <= '0;
            out_addr_o <= '0;
            out_pipe_o <= 1'b0;
        end else if (lane_active) begin
            out_lane_o <= lane_idx;
            out_addr_o <= lane_addr_calc;
            out_pipe_o <= lane_pipe;
        end
    end

    // Sticky error: set by an active unsupported lane, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (start_i) begin
            err_o <= 1'b0;
        end else if (lane_active && lane_bad) begin
            err_o <= 1'b1;
        end
    end

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !err_o)
        else $error("error not cleared by start");

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o)
        else $error("error dropped without start");

    p_out_follows_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(lane_valid_i))
        else $error("output without a lane presented one cycle earlier");

    p_local_is_flat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_pipe_o == PIPE_LOCAL) |-> ctx_q.flat)
        else $error("global instruction routed to local pipe");

    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !ctx_q.flat && ctx_q.sel != SEL_NO_BASE)
            |-> (out_addr_o[ADDR_W-1:NARROW_W] == '0))
        else $error("narrow address has upper bits set");
endmodule

// File: tb/tb_fga_unit.sv
module tb_fga_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;
    localparam int LW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          mode_flat_i;
    logic [6:0]    sel_i;
    logic [31:0]   sbase_i;
    logic [31:0]   offset_i;
    logic [NL-1:0] exec_mask_i;
    logic          lane_valid_i;
    logic [63:0]   lane_addr_i;
    logic [1:0]    lane_seg_i;
    logic          out_valid_o;
    logic [LW-1:0] out_lane_o;
    logic [63:0]   out_addr_o;
    logic          out_pipe_o;
    logic          err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        cur_flat;
    logic [6:0]  cur_sel;
    logic [31:0] cur_sbase;
    logic [31:0] cur_off;

    fga_unit #(.NUM_LANES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_flat_i(mode_flat_i),
        .sel_i(sel_i), .sbase_i(sbase_i), .offset_i(offset_i),
        .exec_mask_i(exec_mask_i), .lane_valid_i(lane_valid_i),
        .lane_addr_i(lane_addr_i), .lane_seg_i(lane_seg_i),
        .out_valid_o(out_valid_o), .out_lane_o(out_lane_o),
        .out_addr_o(out_addr_o), .out_pipe_o(out_pipe_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected address from the addressing rules (R2, R3, R4).
    function automatic logic [63:0] model_addr(input logic [63:0] a);
        logic [31:0] s;
        if (cur_flat || cur_sel == 7'h7F) return a + {32'h0, cur_off};
        s = a[31:0] + cur_sbase + cur_off;
        return {32'h0, s};
    endfunction

    task automatic check_out(input string req, input bit ev, input int el,
                             input logic [63:0] ea, input bit ep, input bit ee);
        bit bad;
        checks++;
        bad = (out_valid_o !== ev) || (err_o !== ee);
        if (ev) bad = bad || (out_lane_o !== LW'(el)) || (out_addr_o !== ea) || (out_pipe_o !== ep);
        if (bad) begin
            errors++;
            $display("FAIL %s: got valid=%0b lane=%0d addr=%h pipe=%0b err=%0b expected valid=%0b lane=%0d addr=%h pipe=%0b err=%0b",
                     req, out_valid_o, out_lane_o, out_addr_o, out_pipe_o, err_o,
                     ev, el, ea, ep, ee);
        end
    endtask

    // Issue a start pulse; returns at the negedge after it.
    task automatic do_start(input logic flat, input logic [6:0] sel,
                            input logic [31:0] sb, input logic [31:0] off,
                            input logic [NL-1:0] mask);
        start_i = 1'b1; mode_flat_i = flat; sel_i = sel; sbase_i = sb;
        offset_i = off; exec_mask_i = mask;
        cur_flat = flat; cur_sel = sel; cur_sbase = sb; cur_off = off;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Present one lane and return at the negedge where its result shows.
    task automatic send_lane(input logic [63:0] a, input logic [1:0] seg);
        lane_valid_i = 1'b1; lane_addr_i = a; lane_seg_i = seg;
        @(negedge clk);
        lane_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        check_out("R1 reset", 0, 0, 64'h0, 0, 0);
    endtask

    task automatic t_global_wide;
        logic [63:0] a;
        do_start(1'b0, 7'h7F, 32'h0000_1234, 32'h10, '1);
        a = 64'h0000_0001_FFFF_FFF8;
        send_lane(a, 2'd0);
        check_out("R2 wide carry", 1, 0, model_addr(a), 0, 0);
        if (model_addr(a) !== 64'h0000_0002_0000_0008) begin
            errors++; $display("FAIL R2 model: got %h expected %h", model_addr(a), 64'h0000_0002_0000_0008);
        end
        send_lane(64'h55, 2'd1);
        check_out("R5 global ignores group seg", 1, 1, 64'h65, 0, 0);
        send_lane(64'h77, 2'd3);
        check_out("R5 global ignores bad seg", 1, 2, 64'h87, 0, 0);
    endtask

    task automatic t_global_narrow;
        do_start(1'b0, 7'h05, 32'h100, 32'h20, '1);
        send_lane(64'hABCD_0000_FFFF_FF00, 2'd0);
        check_out("R4 narrow wrap", 1, 0, 64'h0000_0000_0000_0020, 0, 0);
        send_lane(64'h1_0000_0040, 2'd2);
        check_out("R4 narrow upper dropped", 1, 1, 64'h160, 0, 0);
    endtask

    task automatic t_flat;
        logic [63:0] a;
        do_start(1'b1, 7'h05, 32'hFFFF_0000, 32'h4, '1);
        a = 64'h0000_0010_0000_0000;
        send_lane(a, 2'd0);
        check_out("R3 flat wide despite selector", 1, 0, 64'h0000_0010_0000_0004, 0, 0);
        send_lane(a + 64'h8, 2'd0);
        check_out("R6 flat global pipe", 1, 1, model_addr(a + 64'h8), 0, 0);
        send_lane(64'h300, 2'd1);
        check_out("R6 flat local pipe", 1, 2, 64'h304, 1, 0);
    endtask

    task automatic t_flat_bad;
        do_start(1'b1, 7'h7F, 32'h0, 32'h0, '1);
        send_lane(64'h10, 2'd2);
        check_out("R7 bad seg no output and error", 0, 0, 64'h0, 0, 1);
        send_lane(64'h20, 2'd0);
        check_out("R8 error sticky", 1, 1, 64'h20, 0, 1);
        send_lane(64'h30, 2'd3);
        check_out("R7 seg 3 error", 0, 0, 64'h0, 0, 1);
        do_start(1'b1, 7'h7F, 32'h0, 32'h0, '1);
        check_out("R8 error cleared by start", 0, 0, 64'h0, 0, 0);
    endtask

    task automatic t_mask;
        do_start(1'b0, 7'h7F, 32'h0, 32'h1, 8'b0000_0101);
        send_lane(64'h100, 2'd0);
        check_out("R9 lane0 enabled", 1, 0, 64'h101, 0, 0);
        send_lane(64'h200, 2'd0);
        check_out("R9 lane1 masked", 0, 0, 64'h0, 0, 0);
        send_lane(64'h300, 2'd0);
        check_out("R9 lane2 index kept", 1, 2, 64'h301, 0, 0);
    endtask

    task automatic t_back_to_back;
        do_start(1'b1, 7'h00, 32'h0, 32'h8, '1);
        lane_valid_i = 1'b1; lane_addr_i = 64'h1000; lane_seg_i = 2'd0;
        @(negedge clk);
        check_out("R10 first lane latency", 1, 0, 64'h1008, 0, 0);
        lane_addr_i = 64'h2000; lane_seg_i = 2'd1;
        @(negedge clk);
        check_out("R10 second lane latency", 1, 1, 64'h2008, 1, 0);
        lane_addr_i = 64'h3000; lane_seg_i = 2'd0;
        @(negedge clk);
        lane_valid_i = 1'b0;
        check_out("R10 third lane latency", 1, 2, 64'h3008, 0, 0);
        @(negedge clk);
        check_out("R10 no lane no output", 0, 0, 64'h0, 0, 0);
    endtask

    task automatic t_overflow;
        do_start(1'b0, 7'h7F, 32'h0, 32'h0, '1);
        for (int i = 0; i < NL; i++) begin
            lane_valid_i = 1'b1; lane_addr_i = 64'(i); lane_seg_i = 2'd0;
            @(negedge clk);
        end
        check_out("R11 last lane", 1, NL-1, 64'(NL-1), 0, 0);
        lane_addr_i = 64'hDEAD;
        @(negedge clk);
        lane_valid_i = 1'b0;
        check_out("R11 extra lane ignored", 0, 0, 64'h0, 0, 0);
        start_i = 1'b1; lane_valid_i = 1'b1; lane_addr_i = 64'hBEEF;
        mode_flat_i = 1'b0; sel_i = 7'h7F; sbase_i = 0; offset_i = 0; exec_mask_i = '1;
        cur_flat = 1'b0; cur_sel = 7'h7F; cur_sbase = 0; cur_off = 0;
        @(negedge clk);
        start_i = 1'b0; lane_valid_i = 1'b0;
        check_out("R11 lane in start cycle ignored", 0, 0, 64'h0, 0, 0);
        send_lane(64'h44, 2'd0);
        check_out("R11 numbering restarts at 0", 1, 0, 64'h44, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; mode_flat_i = 1'b0; sel_i = '0;
        sbase_i = '0; offset_i = '0; exec_mask_i = '0; lane_valid_i = 1'b0;
        lane_addr_i = '0; lane_seg_i = '0;
        cur_flat = 1'b0; cur_sel = '0; cur_sbase = '0; cur_off = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global_wide();
        t_global_narrow();
        t_flat();
        t_flat_bad();
        t_mask();
        t_back_to_back();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule